// File: doc/BRIEF.md
# Dynamic Word-to-Byte Bus Sizer

This block connects a 16-bit requester to an external bus whose targets may be 16 or 8 bits wide. A request carries an address, an active-low high-byte enable, write data and a direction flag. The block latches the request and starts an external cycle with a one-cycle address strobe. In the next cycle it samples the width signal returned by the target, together with a per-region flag that forces 16-bit handling. It then waits for a ready input to finish the access.

If a word request meets a byte-wide target, the block splits it. The first byte access carries the low byte. The block then starts a second byte access, with its own strobe, for the high byte at the odd address. Byte-wide targets only use the low data lane, so the block moves high-byte data onto that lane in both directions. It assembles the read result and signals completion with a one-cycle done pulse. An illegal enable combination is rejected without any bus activity.

Top module: `lane_sizer`

## Requirements
- R1: The pair (reqHiEnN, reqAddr[0]) encodes the request: 0/0 is a word, 1/0 is the low byte, 0/1 is the high byte, and 1/1 is illegal. An illegal request accepted while idle starts no bus cycle and raises reqErr for exactly one cycle, in the cycle after acceptance.
- R2: An accepted legal request raises busAddrStb for exactly one cycle, in the cycle after acceptance. During that strobe, busAddr equals the request address and busHiEnN equals the request's high-byte enable.
- R3: The target width is decided in the cycle after each first strobe. The target is treated as 16-bit when busWide is 1 or when regionWide was 1 at acceptance.
- R4: An access that needs no split finishes on the first clock edge at which busReady is 1, counting from the second cycle after the strobe. reqDone is high for one cycle after that edge. With busReady held high, reqDone comes 4 cycles after acceptance, plus one cycle for each wait cycle.
- R5: A word request to an 8-bit target performs two accesses, each with its own strobe. The second access drives busAddr[0]=1 and busHiEnN=1. With no waits, reqDone comes 7 cycles after acceptance.
- R6: In a split write, the first access drives the low write byte on busWdata[7:0]. The second access drives the high write byte on busWdata[7:0].
- R7: In a split read, busRdata[7:0] from the first access lands in reqRdata[7:0]. busRdata[7:0] from the second access lands in reqRdata[15:8].
- R8: A high-byte request to an 8-bit target uses only the low lane: write data goes to busWdata[7:0], and read data comes from busRdata[7:0] into reqRdata[15:8]. To a 16-bit target it uses busRdata[15:8] and busWdata[15:8].
- R9: Result bytes that were not requested read as zero. reqRdata holds its value after reqDone until the next request is accepted.
- R10: For a request whose regionWide was 1, busWideDrv is high while the bus cycle is in progress. It is never high otherwise. Such a request is never split, even when busWide is 0.
- R11: reqValid is ignored while a request is in progress: no extra cycle is started, no error is raised, and the bus address stays stable.
- R12: busDataOe is high only in the data phase of write accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present (accepted only when idle) |
| reqAddr | input | ADDR_W | Request byte address |
| reqHiEnN | input | 1 | Active-low high-byte enable of the request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | 16 | Request write data |
| reqRdata | output | 16 | Assembled read data |
| reqDone | output | 1 | One-cycle completion pulse |
| reqErr | output | 1 | One-cycle illegal-request pulse |
| regionWide | input | 1 | Region forces 16-bit handling |
| busAddr | output | ADDR_W | External address, odd on the second byte access |
| busHiEnN | output | 1 | External active-low high-byte enable |
| busAddrStb | output | 1 | Address strobe, one cycle per access |
| busWrite | output | 1 | Direction of the current external cycle |
| busWdata | output | 16 | Lane-steered write data |
| busDataOe | output | 1 | Write data enable |
| busRdata | input | 16 | External read data |
| busWide | input | 1 | Target reports 16-bit width |
| busWideDrv | output | 1 | Drives the 16-bit indication for a forced region |
| busReady | input | 1 | Target completes the current access |

## Verification
Every request is launched from a falling edge, so that the next rising edge accepts it. Falling edges are then counted until reqDone appears. The count must be 4 for an unsplit access and 7 for a split one, plus the ready waits that the bench's target model inserts. reqErr is checked on the first falling edge after acceptance and must be gone on the second. Strobe count, strobe address and enable, write bytes stored by the target, and result data are all checked once done appears. A few cycles later the result is checked again to confirm that it holds.

// File: rtl/lane_sizer_pkg.sv
package lane_sizer_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 2;
  localparam int DATA_W = BYTE_W * LANES;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STROBE,
    ST_SIZE,
    ST_XFER
  } sizerState_t;

  // strobes and levels from control to datapath
  typedef struct packed {
    logic accept;
    logic sampleWidth;
    logic capture;
    logic secondPhase;
    logic dataPhase;
    logic active;
  } sizerCtl_t;
endpackage

// File: rtl/lane_sizer_ctrl.sv
module lane_sizer_ctrl
  import lane_sizer_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqIllegal,
  input  logic      needSplit,
  input  logic      busReady,
  output sizerCtl_t ctl,
  output logic      busAddrStb,
  output logic      reqDone,
  output logic      reqErr,
  output logic      busy
);
  sizerState_t state;
  logic        phase2;

  always_comb begin
    ctl             = '0;
    ctl.accept      = (state == ST_IDLE) && reqValid && !reqIllegal;
    ctl.sampleWidth = (state == ST_SIZE) && !phase2;
    ctl.capture     = (state == ST_XFER) && busReady;
    ctl.secondPhase = phase2;
    ctl.dataPhase   = (state == ST_XFER);
    ctl.active      = (state != ST_IDLE);
    busAddrStb      = (state == ST_STROBE);
    busy            = (state != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      phase2  <= 1'b0;
      reqDone <= 1'b0;
      reqErr  <= 1'b0;
    end else begin
      reqDone <= 1'b0;
      reqErr  <= 1'b0;
      case (state)
        ST_IDLE: begin
          phase2 <= 1'b0;
          if (reqValid) begin
            if (reqIllegal) reqErr <= 1'b1;
            else            state  <= ST_STROBE;
          end
        end
        ST_STROBE: state <= ST_SIZE;
        ST_SIZE:   state <= ST_XFER;
        ST_XFER: begin
          if (busReady) begin
            if (needSplit && !phase2) begin
              phase2 <= 1'b1;
              state  <= ST_STROBE;
            end else begin
              state   <= ST_IDLE;
              reqDone <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lane_sizer_dp.sv
module lane_sizer_dp
  import lane_sizer_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  sizerCtl_t         ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqHiEnN,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              regionWide,
  input  logic              busWide,
  input  logic [DATA_W-1:0] busRdata,
  output logic              reqIllegal,
  output logic              needSplit,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busHiEnN,
  output logic              busWrite,
  output logic [DATA_W-1:0] busWdata,
  output logic              busDataOe,
  output logic              busWideDrv,
  output logic [DATA_W-1:0] reqRdata
);
  logic [ADDR_W-1:0] addrQ;
  logic              hiEnNQ, writeQ, forceQ, wideQ;
  logic [DATA_W-1:0] wdataQ;
  logic              wordQ, upperByteAccess, laneSwap;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      hiEnNQ <= 1'b1;
      writeQ <= 1'b0;
      wdataQ <= '0;
      forceQ <= 1'b0;
      wideQ  <= 1'b0;
    end else if (ctl.accept) begin
      addrQ  <= reqAddr;
      hiEnNQ <= reqHiEnN;
      writeQ <= reqWrite;
      wdataQ <= reqWdata;
      forceQ <= regionWide;
      wideQ  <= 1'b0;
    end else if (ctl.sampleWidth) begin
      wideQ <= busWide | forceQ;
    end
  end

  always_comb begin
    reqIllegal      = reqHiEnN & reqAddr[0];
    wordQ           = !hiEnNQ && !addrQ[0];
    needSplit       = wordQ && !wideQ;
    upperByteAccess = ctl.secondPhase || addrQ[0];
    laneSwap        = !wideQ && upperByteAccess;
    busAddr         = {addrQ[ADDR_W-1:1], addrQ[0] | ctl.secondPhase};
    busHiEnN        = hiEnNQ | ctl.secondPhase;
    busWrite        = writeQ && ctl.active;
    busDataOe       = writeQ && ctl.dataPhase;
    busWideDrv      = forceQ && ctl.active;
    busWdata        = {wdataQ[DATA_W-1:BYTE_W],
                       laneSwap ? wdataQ[DATA_W-1:BYTE_W] : wdataQ[BYTE_W-1:0]};
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic              laneReq, laneTake;
    logic [BYTE_W-1:0] laneSrc, laneQ;

    always_comb begin
      laneReq  = (g == 0) ? !addrQ[0] : !hiEnNQ;
      laneTake = wideQ ? laneReq : (upperByteAccess == (g == 1));
      laneSrc  = wideQ ? busRdata[g*BYTE_W +: BYTE_W] : busRdata[BYTE_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rstN)                        laneQ <= '0;
      else if (ctl.accept)              laneQ <= '0;
      else if (ctl.capture && laneTake) laneQ <= laneSrc;
    end

    assign reqRdata[g*BYTE_W +: BYTE_W] = laneQ;
  end
endmodule

// File: rtl/lane_sizer.sv
module lane_sizer
  import lane_sizer_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqHiEnN,
  input  logic              reqWrite,
  input  logic [15:0]       reqWdata,
  output logic [15:0]       reqRdata,
  output logic              reqDone,
  output logic              reqErr,
  input  logic              regionWide,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busHiEnN,
  output logic              busAddrStb,
  output logic              busWrite,
  output logic [15:0]       busWdata,
  output logic              busDataOe,
  input  logic [15:0]       busRdata,
  input  logic              busWide,
  output logic              busWideDrv,
  input  logic              busReady
);
  sizerCtl_t ctl;
  logic      reqIllegal, needSplit, sizerBusy;

  lane_sizer_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqIllegal (reqIllegal),
    .needSplit  (needSplit),
    .busReady   (busReady),
    .ctl        (ctl),
    .busAddrStb (busAddrStb),
    .reqDone    (reqDone),
    .reqErr     (reqErr),
    .busy       (sizerBusy)
  );

  lane_sizer_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .reqAddr    (reqAddr),
    .reqHiEnN   (reqHiEnN),
    .reqWrite   (reqWrite),
    .reqWdata   (reqWdata),
    .regionWide (regionWide),
    .busWide    (busWide),
    .busRdata   (busRdata),
    .reqIllegal (reqIllegal),
    .needSplit  (needSplit),
    .busAddr    (busAddr),
    .busHiEnN   (busHiEnN),
    .busWrite   (busWrite),
    .busWdata   (busWdata),
    .busDataOe  (busDataOe),
    .busWideDrv (busWideDrv),
    .reqRdata   (reqRdata)
  );
endmodule

// File: rtl/lane_sizer_chk.sv
module lane_sizer_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqHiEnN,
  input logic              reqDone,
  input logic              reqErr,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busHiEnN,
  input logic              busAddrStb,
  input logic              busWrite,
  input logic              busDataOe,
  input logic              busWideDrv,
  input logic              busReady,
  input logic              sizerBusy
);
  AST_ILLEGAL_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (!sizerBusy && reqValid && reqHiEnN && reqAddr[0]) |=> (reqErr && !busAddrStb)); // R1
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    busAddrStb |=> !busAddrStb); // R2
  AST_SECOND_ODD: assert property (@(posedge clk) disable iff (!rstN)
    (busAddrStb && $past(sizerBusy)) |-> (busAddr[0] && busHiEnN)); // R5
  AST_DONE_AFTER_READY: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |-> $past(busReady)); // R4
  AST_FORCE_IN_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    busWideDrv |-> sizerBusy); // R10
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (sizerBusy && $past(sizerBusy) && !busAddrStb) |-> $stable(busAddr)); // R11
  AST_OE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    busDataOe |-> busWrite); // R12
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(reqDone && reqErr)); // R1
endmodule

bind lane_sizer lane_sizer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqAddr    (reqAddr),
  .reqHiEnN   (reqHiEnN),
  .reqDone    (reqDone),
  .reqErr     (reqErr),
  .busAddr    (busAddr),
  .busHiEnN   (busHiEnN),
  .busAddrStb (busAddrStb),
  .busWrite   (busWrite),
  .busDataOe  (busDataOe),
  .busWideDrv (busWideDrv),
  .busReady   (busReady),
  .sizerBusy  (sizerBusy)
);

// File: tb/lane_sizer_bench.sv
`timescale 1ns/1ps
module lane_sizer_bench;
  localparam int ADDR_W = 24;
  localparam logic [ADDR_W-2:0] BASE = 23'h12_34AB;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqHiEnN = 1'b1, reqWrite = 1'b0, regionWide = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [15:0] reqRdata, busWdata, busRdata;
  logic reqDone, reqErr, busHiEnN, busAddrStb, busWrite, busDataOe, busWide, busWideDrv, busReady;
  logic [ADDR_W-1:0] busAddr;

  int checkCount = 0;
  int failCount  = 0;

  // target model controls
  logic tgtData16 = 1'b1, tgtCs = 1'b1, preload = 1'b0, clr = 1'b0;
  logic [7:0] pre0 = '0, pre1 = '0, mem0, mem1;
  int tgtWait = 0;
  int cnt, stbCount;
  logic stbA0 [2];
  logic stbHi [2];
  logic stbAddrOk [2];
  logic drvSeen, oeSeen;

  always #2.5 clk = ~clk;

  lane_sizer #(.ADDR_W(ADDR_W)) u_lane_sizer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqHiEnN(reqHiEnN), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .reqRdata(reqRdata), .reqDone(reqDone), .reqErr(reqErr),
    .regionWide(regionWide), .busAddr(busAddr), .busHiEnN(busHiEnN),
    .busAddrStb(busAddrStb), .busWrite(busWrite), .busWdata(busWdata),
    .busDataOe(busDataOe), .busRdata(busRdata), .busWide(busWide),
    .busWideDrv(busWideDrv), .busReady(busReady)
  );

  assign busWide  = tgtCs;
  assign busReady = (cnt >= 1 + tgtWait);
  assign busRdata = tgtData16 ? {mem1, mem0} : {8'hEE, (busAddr[0] ? mem1 : mem0)};

  always @(posedge clk) begin
    if (busAddrStb) cnt <= 0;
    else            cnt <= cnt + 1;
    if (preload) begin
      mem0 <= pre0;
      mem1 <= pre1;
    end else if (busDataOe && busReady) begin
      if (tgtData16) begin
        if (!busHiEnN)  mem1 <= busWdata[15:8];
        if (!busAddr[0]) mem0 <= busWdata[7:0];
      end else if (busAddr[0]) mem1 <= busWdata[7:0];
      else                     mem0 <= busWdata[7:0];
    end
    if (clr) begin
      stbCount <= 0;
      drvSeen  <= 1'b0;
      oeSeen   <= 1'b0;
    end else begin
      if (busWideDrv) drvSeen <= 1'b1;
      if (busDataOe)  oeSeen  <= 1'b1;
      if (busAddrStb) begin
        if (stbCount < 2) begin
          stbA0[stbCount]     <= busAddr[0];
          stbHi[stbCount]     <= busHiEnN;
          stbAddrOk[stbCount] <= (busAddr[ADDR_W-1:1] == BASE);
        end
        stbCount <= stbCount + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic setup(input logic frc, input logic d16, input logic cs, input int wt,
                       input logic [7:0] p0, input logic [7:0] p1);
    @(negedge clk);
    regionWide = frc; tgtData16 = d16; tgtCs = cs; tgtWait = wt;
    pre0 = p0; pre1 = p1; preload = 1'b1; clr = 1'b1;
    @(negedge clk);
    preload = 1'b0; clr = 1'b0;
  endtask

  // one request, fully checked
  task automatic doReq(input string rq, input logic hiEnN, input logic a0, input logic wr,
                       input logic [15:0] wd, input logic frc, input logic d16, input logic cs,
                       input int wt, input logic [7:0] p0, input logic [7:0] p1,
                       input logic [15:0] expRd, input int expLat, input int expStb,
                       input logic [7:0] e0, input logic [7:0] e1);
    int lat;
    logic [15:0] held;
    setup(frc, d16, cs, wt, p0, p1);
    reqValid = 1'b1; reqHiEnN = hiEnN; reqAddr = {BASE, a0}; reqWrite = wr; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    while (!reqDone && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == expLat, {rq, " done latency"}, lat, expLat);
    chk(stbCount == expStb, {rq, " strobe count"}, stbCount, expStb);
    chk(stbA0[0] == a0 && stbHi[0] == hiEnN && stbAddrOk[0], {rq, " R2 first strobe addr/enable"},
        {stbAddrOk[0], stbA0[0], stbHi[0]}, {1'b1, a0, hiEnN});
    if (expStb == 2)
      chk(stbA0[1] && stbHi[1] && stbAddrOk[1], {rq, " R5 second strobe odd, enable off"},
          {stbAddrOk[1], stbA0[1], stbHi[1]}, 3'b111);
    chk(drvSeen == frc, {rq, " R10 forced width drive"}, drvSeen, frc);
    chk(oeSeen == wr, {rq, " R12 data enable only on writes"}, oeSeen, wr);
    if (wr) chk(mem0 == e0 && mem1 == e1, {rq, " target bytes"}, {mem1, mem0}, {e1, e0});
    else    chk(reqRdata == expRd, {rq, " read data"}, reqRdata, expRd);
    held = reqRdata;
    repeat (3) @(negedge clk);
    chk(reqRdata == held && !reqDone && !reqErr, {rq, " R9 result held, single done"},
        {reqDone, reqErr, reqRdata}, {2'b00, held});
  endtask

  task automatic testIllegal();
    setup(1'b0, 1'b1, 1'b1, 0, 8'h00, 8'h00);
    reqValid = 1'b1; reqHiEnN = 1'b1; reqAddr = {BASE, 1'b1}; reqWrite = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    chk(reqErr && !busAddrStb, "R1 illegal: error pulse, no strobe", {reqErr, busAddrStb}, 2'b10);
    @(negedge clk);
    chk(!reqErr, "R1 illegal: error lasts one cycle", reqErr, 0);
    repeat (4) @(negedge clk);
    chk(stbCount == 0 && !reqDone, "R1 illegal: no bus cycle", stbCount, 0);
  endtask

  task automatic testBusyIgnore();
    int lat;
    setup(1'b0, 1'b0, 1'b0, 0, 8'hC3, 8'h5A);
    reqValid = 1'b1; reqHiEnN = 1'b0; reqAddr = {BASE, 1'b0}; reqWrite = 1'b0;
    @(negedge clk);
    reqValid = 1'b0; lat = 1;
    @(negedge clk); lat++;
    // illegal code then a legal write while busy
    reqValid = 1'b1; reqHiEnN = 1'b1; reqAddr = {BASE, 1'b1};
    @(negedge clk); lat++;
    chk(!reqErr, "R11 no error while busy", reqErr, 0);
    reqHiEnN = 1'b0; reqAddr = {~BASE, 1'b0}; reqWrite = 1'b1;
    @(negedge clk); lat++;
    reqValid = 1'b0; reqWrite = 1'b0;
    while (!reqDone && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == 7, "R11 busy: latency unchanged", lat, 7);
    chk(reqRdata == 16'h5AC3, "R11 busy: result of first request", reqRdata, 16'h5AC3);
    repeat (6) @(negedge clk);
    chk(stbCount == 2 && !oeSeen, "R11 busy: no extra cycle", stbCount, 2);
  endtask

  initial begin
    #(200000 * 5);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busAddrStb && !reqDone && !reqErr && !busDataOe && !busWideDrv && reqRdata == 16'h0,
        "R2 R9 reset state", {busAddrStb, reqDone, reqErr, busDataOe, busWideDrv, reqRdata}, 0);
    // R3 R4 wide word read
    doReq("R4 wide word read", 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b1, 1'b1, 0,
          8'h34, 8'h12, 16'h1234, 4, 1, 8'h0, 8'h0);
    // R4 wide word write with two wait cycles
    doReq("R4 wide word write", 1'b0, 1'b0, 1'b1, 16'hBEEF, 1'b0, 1'b1, 1'b1, 2,
          8'h00, 8'h00, 16'h0, 6, 1, 8'hEF, 8'hBE);
    // R3 R5 R7 split read
    doReq("R7 split read", 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 0,
          8'h78, 8'h56, 16'h5678, 7, 2, 8'h0, 8'h0);
    // R5 R6 split write, one wait per access
    doReq("R6 split write", 1'b0, 1'b0, 1'b1, 16'hA1B2, 1'b0, 1'b0, 1'b0, 1,
          8'h00, 8'h00, 16'h0, 9, 2, 8'hB2, 8'hA1);
    // R9 low byte from byte target: upper result lane zero
    doReq("R9 byte-target low read", 1'b1, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 0,
          8'h9C, 8'h44, 16'h009C, 4, 1, 8'h0, 8'h0);
    // R8 high byte from byte target, on low lane
    doReq("R8 byte-target high read", 1'b0, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 0,
          8'h11, 8'h6D, 16'h6D00, 4, 1, 8'h0, 8'h0);
    doReq("R8 byte-target high write", 1'b0, 1'b1, 1'b1, 16'h3C99, 1'b0, 1'b0, 1'b0, 0,
          8'h55, 8'h00, 16'h0, 4, 1, 8'h55, 8'h3C);
    doReq("R8 wide-target high read", 1'b0, 1'b1, 1'b0, 16'h0, 1'b0, 1'b1, 1'b1, 0,
          8'h22, 8'h7E, 16'h7E00, 4, 1, 8'h0, 8'h0);
    // R10 R3 forced region: target returns no width, still one access
    doReq("R10 forced-region word read", 1'b0, 1'b0, 1'b0, 16'h0, 1'b1, 1'b1, 1'b0, 0,
          8'hCD, 8'hAB, 16'hABCD, 4, 1, 8'h0, 8'h0);
    testIllegal();
    testBusyIgnore();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end
endmodule